// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt sources and hands one of them to a CPU as a fixed 16-bit vector address. The sources are two active-low external pins, two timer overflow pulses, and one serial source that merges a transmit-done pulse and a receive-done pulse. Software reaches four small registers through a simple write/read port. They hold the master and per-source enables, one priority bit per source, the trigger mode of each external pin, and the request flags.

The CPU watches `irq_valid` and `irq_vector`. It pulses `irq_ack` to take the vector on offer and pulses `irq_reti` when a handler returns. Two in-service levels are tracked. A high-priority request may interrupt a low-priority handler. Nothing interrupts a high-priority handler, and a low-priority request never interrupts a low-priority handler. Each kind of flag clears in its own way: timer flags and edge-mode external flags clear on acknowledge, level-mode external flags follow the pin, and serial flags clear only when software writes them.

Top module: `vic2_ctrl`

## Requirements
- R1: The vector for source index 0..4 (external 0, timer 0, external 1, timer 1, serial) is 0x0003, 0x000B, 0x0013, 0x001B and 0x0023 respectively. `irq_vector` reads 0 while `irq_valid` is low.
- R2: When sources of both levels are eligible and no handler blocks them, a source whose priority bit is 1 (high) is offered before any source whose bit is 0 (low).
- R3: Among eligible sources of the same level, the lowest index wins: external 0, then timer 0, then external 1, then timer 1, then serial.
- R4: A source is eligible only when the master enable (register 0 bit 7) and its own enable (register 0 bit = source index) are both 1. Disabled sources still latch their flags.
- R5: Trigger-mode bit k (register 2 bit k) selects level mode (0) or falling-edge mode (1) for external pin k. In level mode the flag equals the inverted pin, delayed by one clock. In edge mode the flag sets when the previous sample was high and the current sample is low.
- R6: A timer flag clears on the clock where its vector is acknowledged. Software can also clear it by writing the flag register.
- R7: Acknowledge never clears the transmit or receive flag. Writing the flag register is the only way to clear them. Either flag alone raises the serial request.
- R8: While a high-level handler is in service, `irq_valid` stays low. While only a low-level handler is in service, only high-priority sources are offered.
- R9: A return pulse ends the high-level handler if one is in service, and otherwise ends the low-level handler.
- R10: An edge-mode external flag clears on acknowledge and does not set again while the pin stays low. A level-mode flag is not cleared by acknowledge.
- R11: After reset all registers read 0, both pins are treated as high, nothing is in service, and `irq_valid` is low.
- R12: Register map. Register 0 holds the master enable (bit 7) and the source enables (bits 4:0). Register 1 holds the priority bits (4:0). Register 2 holds the trigger modes (1:0). Register 3 holds the flags: external 0 (bit 0), timer 0 (bit 1), external 1 (bit 2), timer 1 (bit 3), transmit (bit 4) and receive (bit 5). Unused bits read 0. A write to register 3 replaces every flag except a level-mode flag, and a hardware set in the same clock wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_n | input | 2 | External request pins, active low, already synchronous |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_tx_done | input | 1 | Serial transmit-done pulse |
| ser_rx_done | input | 1 | Serial receive-done pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq_valid | output | 1 | A vector is on offer |
| irq_vector | output | 16 | Vector address of the offered source |
| irq_ack | input | 1 | CPU takes the offered vector |
| irq_reti | input | 1 | CPU returns from the current handler |

## Verification
The bench first raises each source on its own, which separates the five vector addresses. It then raises all sources together under several priority settings, which shows whether the fixed order or the priority bit decides. Nesting is driven as acknowledge/return sequences with high and low requests arriving mid-handler; these show preemption, blocking and which level a return ends. The two trigger modes are exercised by holding pins low across acknowledges and by re-toggling them. A long seeded random mix of pins, pulses, register writes, acknowledges and returns is then compared each clock against a bench model of flags and in-service state.

// File: rtl/vic2_pkg.sv
// Shared constants and helpers for the two-level vectored interrupt controller.
// Assumes five sources indexed 0..4 in the fixed polling order.
package vic2_pkg;
    localparam int NSRC       = 5;
    localparam int SRC_W      = 3;
    localparam int NEXT       = 2;
    localparam int NFLAG      = 6;
    localparam int VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_STRIDE = 8;

    typedef enum logic [1:0] {
        REG_ENA  = 2'd0,
        REG_PRI  = 2'd1,
        REG_TRIG = 2'd2,
        REG_FLAG = 2'd3
    } reg_sel_e;

    // Vector address of a source index.
    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/vic2_flags.sv
// Request flag store. It holds the edge detectors and the per-type clear rules.
// Assumes the pins are already synchronous to clk and that the pulses last one clock.
module vic2_flags
    import vic2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NEXT-1:0]    pin_n,
    input  logic [NEXT-1:0]    trig_edge,
    input  logic [NEXT-1:0]    tmr_ovf,
    input  logic               tx_done,
    input  logic               rx_done,
    input  logic               wr_flags,
    input  logic [NFLAG-1:0]   wdata,
    input  logic               clr_valid,
    input  logic [SRC_W-1:0]   clr_idx,
    output logic [NFLAG-1:0]   flags,
    output logic [NSRC-1:0]    req
);
    logic [NEXT-1:0] pin_q;
    logic [NEXT-1:0] ext_f;
    logic [NEXT-1:0] tmr_f;
    logic [1:0]      ser_f;

    // Previous pin sample, used by the falling-edge detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '1;
        else        pin_q <= pin_n;
    end

    for (genvar k = 0; k < NEXT; k++) begin : g_src
        localparam int EI = 2 * k;
        localparam int TI = 2 * k + 1;
        logic fall;
        logic ack_ext;
        logic ack_tmr;
        assign fall    = pin_q[k] & ~pin_n[k];
        assign ack_ext = clr_valid && (clr_idx == SRC_W'(EI));
        assign ack_tmr = clr_valid && (clr_idx == SRC_W'(TI));

        // External flag: follows the pin in level mode, latches a fall in edge mode.
        always_ff @(posedge clk) begin
            if (!rst_n)             ext_f[k] <= 1'b0;
            else if (!trig_edge[k]) ext_f[k] <= ~pin_n[k];
            else if (fall)          ext_f[k] <= 1'b1;
            else if (wr_flags)      ext_f[k] <= wdata[EI];
            else if (ack_ext)       ext_f[k] <= 1'b0;
        end

        // Timer flag: set by overflow, cleared by a write or by its acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        tmr_f[k] <= 1'b0;
            else if (tmr_ovf[k]) tmr_f[k] <= 1'b1;
            else if (wr_flags) tmr_f[k] <= wdata[TI];
            else if (ack_tmr)  tmr_f[k] <= 1'b0;
        end

        p_tmr_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_tmr && !tmr_ovf[k] && !wr_flags) |=> !tmr_f[k]);
        p_edge_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_edge[k] && ack_ext && !fall && !wr_flags) |=> !ext_f[k]);
    end

    // Serial flags: set by the done pulses and cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_f <= '0;
        end else begin
            ser_f[0] <= tx_done | (wr_flags ? wdata[4] : ser_f[0]);
            ser_f[1] <= rx_done | (wr_flags ? wdata[5] : ser_f[1]);
        end
    end

    p_ser_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_f[0] && !wr_flags) |=> ser_f[0]);

    assign flags = {ser_f, tmr_f[1], ext_f[1], tmr_f[0], ext_f[0]};
    assign req   = {ser_f[0] | ser_f[1], tmr_f[1], ext_f[1], tmr_f[0], ext_f[0]};
endmodule

// File: rtl/vic2_arbiter.sv
// Priority picker: the level first, then the fixed index order inside the level.
// Assumes elig is already gated by the enables; the in-service state masks what may be offered.
module vic2_arbiter
    import vic2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    elig,
    input  logic [NSRC-1:0]    prio,
    input  logic               hi_act,
    input  logic               lo_act,
    output logic               valid,
    output logic [SRC_W-1:0]   sel,
    output logic               sel_hi
);
    logic [NSRC-1:0] allow;
    logic [NSRC-1:0] cand_hi;
    logic [NSRC-1:0] cand_lo;
    logic [NSRC-1:0] pick_set;

    // Mask by in-service level, choose the level, then the lowest index.
    always_comb begin
        allow    = hi_act ? '0 : (lo_act ? prio : '1);
        cand_hi  = elig & prio & allow;
        cand_lo  = elig & ~prio & allow;
        pick_set = (|cand_hi) ? cand_hi : cand_lo;
        sel_hi   = |cand_hi;
        valid    = |pick_set;
        sel      = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick_set[i]) sel = SRC_W'(i);
        end
    end

    p_hi_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_act |-> !valid);
    p_lo_only_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_act && valid) |-> prio[sel]);
    p_sel_is_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> elig[sel]);
endmodule

// File: rtl/vic2_nest.sv
// In-service level tracker for the two priority levels.
// Assumes accept is only raised for an offered vector; a return ends the highest active level.
module vic2_nest (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic accept_hi,
    input  logic reti,
    output logic hi_act,
    output logic lo_act
);
    logic hi_nx;
    logic lo_nx;

    // Apply the return first, then the new entry.
    always_comb begin
        hi_nx = hi_act;
        lo_nx = lo_act;
        if (reti) begin
            if (hi_act) hi_nx = 1'b0;
            else        lo_nx = 1'b0;
        end
        if (accept) begin
            if (accept_hi) hi_nx = 1'b1;
            else           lo_nx = 1'b1;
        end
    end

    // Level state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_act <= 1'b0;
            lo_act <= 1'b0;
        end else begin
            hi_act <= hi_nx;
            lo_act <= lo_nx;
        end
    end

    p_no_entry_under_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !hi_act);
    p_reti_pops_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && hi_act && !accept) |=> (!hi_act && (lo_act == $past(lo_act))));
endmodule

// File: rtl/vic2_ctrl.sv
// Top of the two-level vectored interrupt controller: registers, flags, picker, nesting.
// Assumes a CPU that raises irq_ack only while irq_valid is high and irq_reti once per handler.
module vic2_ctrl
    import vic2_pkg::*;
#(
    parameter int REG_AW = 2,
    parameter int REG_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXT-1:0]   ext_pin_n,
    input  logic [NEXT-1:0]   tmr_ovf,
    input  logic              ser_tx_done,
    input  logic              ser_rx_done,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ack,
    input  logic              irq_reti
);
    logic            ea;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] prio;
    logic [NEXT-1:0] trig;
    logic [NFLAG-1:0] flags;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] elig;
    logic [SRC_W-1:0] sel;
    logic            sel_hi;
    logic            hi_act;
    logic            lo_act;
    logic            accept;
    logic            wr_flags;
    reg_sel_e        rsel;

    assign rsel     = reg_sel_e'(reg_addr[1:0]);
    assign wr_flags = reg_we && (rsel == REG_FLAG);

    // Software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea   <= 1'b0;
            en   <= '0;
            prio <= '0;
            trig <= '0;
        end else if (reg_we) begin
            case (rsel)
                REG_ENA: begin
                    ea <= reg_wdata[REG_DW-1];
                    en <= reg_wdata[NSRC-1:0];
                end
                REG_PRI:  prio <= reg_wdata[NSRC-1:0];
                REG_TRIG: trig <= reg_wdata[NEXT-1:0];
                default:  ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (rsel)
            REG_ENA: begin
                reg_rdata[REG_DW-1]  = ea;
                reg_rdata[NSRC-1:0]  = en;
            end
            REG_PRI:  reg_rdata[NSRC-1:0]  = prio;
            REG_TRIG: reg_rdata[NEXT-1:0]  = trig;
            default:  reg_rdata[NFLAG-1:0] = flags;
        endcase
    end

    vic2_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_pin_n),
        .trig_edge (trig),
        .tmr_ovf   (tmr_ovf),
        .tx_done   (ser_tx_done),
        .rx_done   (ser_rx_done),
        .wr_flags  (wr_flags),
        .wdata     (reg_wdata[NFLAG-1:0]),
        .clr_valid (accept),
        .clr_idx   (sel),
        .flags     (flags),
        .req       (req)
    );

    assign elig = {NSRC{ea}} & en & req;

    vic2_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .prio   (prio),
        .hi_act (hi_act),
        .lo_act (lo_act),
        .valid  (irq_valid),
        .sel    (sel),
        .sel_hi (sel_hi)
    );

    assign accept     = irq_ack && irq_valid;
    assign irq_vector = irq_valid ? vec_of(sel) : '0;

    vic2_nest u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .accept_hi (sel_hi),
        .reti      (irq_reti),
        .hi_act    (hi_act),
        .lo_act    (lo_act)
    );

    p_vec_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((irq_vector[2:0] == 3'b011) && (irq_vector <= 16'h0023)));
    p_master_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ea |-> !irq_valid);
    p_idle_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vector == '0));
endmodule

// File: tb/test_vic2_ctrl.sv
`timescale 1ns/1ps
module test_vic2_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_tx_done = 1'b0;
    logic        ser_rx_done = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_valid;
    logic [15:0] irq_vector;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state.
    logic       m_ea = 1'b0;
    logic [4:0] m_en = '0, m_pr = '0;
    logic [1:0] m_tr = '0, m_pq = 2'b11;
    logic [5:0] m_fl = '0;
    logic       m_hi = 1'b0, m_lo = 1'b0;

    always #2.5 clk = ~clk;

    vic2_ctrl i_vic2_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
        .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .irq_ack(irq_ack), .irq_reti(irq_reti)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected offer {valid, index}, from R2, R3, R4 and R8.
    function automatic logic [3:0] m_pick();
        logic [4:0] rq, el, msk, ch, cl, ps;
        rq  = {m_fl[4] | m_fl[5], m_fl[3], m_fl[2], m_fl[1], m_fl[0]};
        el  = m_ea ? (rq & m_en) : 5'b0;
        msk = m_hi ? 5'b0 : (m_lo ? m_pr : 5'h1f);
        ch  = el & m_pr & msk;
        cl  = el & ~m_pr & msk;
        ps  = (ch != 0) ? ch : cl;
        for (int i = 0; i < 5; i++) if (ps[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    function automatic logic [15:0] m_vec(input logic [3:0] p);
        return p[3] ? (16'h0003 + 16'(p[2:0]) * 16'd8) : 16'h0000;
    endfunction

    // One clock: predict, clock, clear pulses, compare at the falling edge.
    task automatic tick();
        logic [3:0] p;
        logic acc, wf, nh, nl;
        logic [5:0] nf;
        p  = m_pick();
        acc = irq_ack && p[3];
        wf = reg_we && reg_addr == 2'd3;
        for (int k = 0; k < 2; k++) begin
            if (!m_tr[k])                       nf[2*k] = ~ext_pin_n[k];
            else if (m_pq[k] && !ext_pin_n[k])  nf[2*k] = 1'b1;
            else if (wf)                        nf[2*k] = reg_wdata[2*k];
            else if (acc && p[2:0] == 3'(2*k))  nf[2*k] = 1'b0;
            else                                nf[2*k] = m_fl[2*k];
            if (tmr_ovf[k])                        nf[2*k+1] = 1'b1;
            else if (wf)                           nf[2*k+1] = reg_wdata[2*k+1];
            else if (acc && p[2:0] == 3'(2*k+1))   nf[2*k+1] = 1'b0;
            else                                   nf[2*k+1] = m_fl[2*k+1];
        end
        nf[4] = ser_tx_done | (wf ? reg_wdata[4] : m_fl[4]);
        nf[5] = ser_rx_done | (wf ? reg_wdata[5] : m_fl[5]);
        nh = m_hi; nl = m_lo;
        if (irq_reti) begin if (m_hi) nh = 1'b0; else nl = 1'b0; end
        if (acc) begin if (m_pr[p[2:0]]) nh = 1'b1; else nl = 1'b1; end
        @(posedge clk);
        if (reg_we) begin
            case (reg_addr)
                2'd0: begin m_ea = reg_wdata[7]; m_en = reg_wdata[4:0]; end
                2'd1: m_pr = reg_wdata[4:0];
                2'd2: m_tr = reg_wdata[1:0];
                default: ;
            endcase
        end
        m_fl = nf; m_pq = ext_pin_n; m_hi = nh; m_lo = nl;
        #1;
        tmr_ovf = 2'b00; ser_tx_done = 1'b0; ser_rx_done = 1'b0;
        reg_we = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
        @(negedge clk);
        p = m_pick();
        chk("R2 R3 R8 model valid", 32'(irq_valid), 32'(p[3]));
        chk("R1 R3 model vector", 32'(irq_vector), 32'(m_vec(p)));
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic expect_offer(input logic v, input logic [15:0] vec, input string tag);
        chk(tag, {15'd0, irq_valid, irq_vector}, {15'd0, v, vec});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        expect_offer(1'b0, 16'h0, "R11 no offer after reset");
        for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R11 register reset value");
        // R12 readback and unused bits
        wr(2'd0, 8'hFF); rd(2'd0, 8'h9F, "R12 enable register readback");
        wr(2'd1, 8'h15); rd(2'd1, 8'h15, "R12 priority register readback");
        wr(2'd2, 8'hFF); rd(2'd2, 8'h03, "R12 trigger register readback");
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h9F);
        // R1 each source alone
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: ext_pin_n[0] = 1'b0;
                1: tmr_ovf[0] = 1'b1;
                2: ext_pin_n[1] = 1'b0;
                3: tmr_ovf[1] = 1'b1;
                default: ser_tx_done = 1'b1;
            endcase
            tick();
            expect_offer(1'b1, 16'h0003 + 16'(i) * 16'd8, "R1 single source vector");
            ext_pin_n = 2'b11;
            wr(2'd3, 8'h00);
            expect_offer(1'b0, 16'h0, "R1 idle after clear");
        end
        // R3 then R2
        ext_pin_n = 2'b00; tmr_ovf = 2'b11; ser_tx_done = 1'b1; tick();
        expect_offer(1'b1, 16'h0003, "R3 lowest index first");
        wr(2'd1, 8'h10); expect_offer(1'b1, 16'h0023, "R2 high serial beats low");
        wr(2'd1, 8'h08); expect_offer(1'b1, 16'h001B, "R2 high timer1 wins");
        // R8 / R9 / R6 / R10 nesting
        irq_ack = 1'b1; tick();
        expect_offer(1'b0, 16'h0, "R8 blocked under high handler");
        rd(2'd3, 8'h17, "R6 timer1 flag cleared by ack");
        irq_reti = 1'b1; tick();
        expect_offer(1'b1, 16'h0003, "R9 return ends high level");
        irq_ack = 1'b1; tick();
        rd(2'd3, 8'h17, "R10 level flag kept on ack");
        expect_offer(1'b0, 16'h0, "R8 low not nested in low");
        tmr_ovf[1] = 1'b1; tick();
        expect_offer(1'b1, 16'h001B, "R8 high preempts low handler");
        irq_ack = 1'b1; tick();
        irq_reti = 1'b1; tick();
        expect_offer(1'b0, 16'h0, "R9 low handler still in service");
        irq_reti = 1'b1; tick();
        expect_offer(1'b1, 16'h0003, "R9 second return ends low level");
        // R4 gating
        wr(2'd0, 8'h1F);
        expect_offer(1'b0, 16'h0, "R4 master off");
        rd(2'd3, 8'h17, "R4 flags still latched");
        wr(2'd0, 8'h9E);
        expect_offer(1'b1, 16'h000B, "R4 ext0 disabled skips it");
        // R7 serial
        wr(2'd0, 8'h90);
        expect_offer(1'b1, 16'h0023, "R7 serial offered");
        irq_ack = 1'b1; tick();
        irq_reti = 1'b1; tick();
        expect_offer(1'b1, 16'h0023, "R7 ack keeps serial flag");
        wr(2'd3, 8'h20);
        expect_offer(1'b1, 16'h0023, "R7 receive flag alone requests");
        wr(2'd3, 8'h00);
        expect_offer(1'b0, 16'h0, "R7 software clear");
        // R6 software clear
        wr(2'd0, 8'h82);
        tmr_ovf[0] = 1'b1; tick();
        expect_offer(1'b1, 16'h000B, "R6 timer0 set");
        wr(2'd3, 8'h00);
        expect_offer(1'b0, 16'h0, "R6 software clears timer flag");
        // R5 / R10 edge mode
        ext_pin_n = 2'b11; tick();
        wr(2'd2, 8'h01); wr(2'd0, 8'h81);
        expect_offer(1'b0, 16'h0, "R5 edge mode idle");
        ext_pin_n[0] = 1'b0; tick();
        expect_offer(1'b1, 16'h0003, "R5 falling edge sets flag");
        irq_ack = 1'b1; tick();
        irq_reti = 1'b1; tick();
        expect_offer(1'b0, 16'h0, "R10 edge flag cleared, pin still low");
        ext_pin_n[0] = 1'b1; tick();
        ext_pin_n[0] = 1'b0; tick();
        expect_offer(1'b1, 16'h0003, "R5 second edge sets again");
        wr(2'd3, 8'h00); ext_pin_n[0] = 1'b1; tick();
        wr(2'd2, 8'h00);
        ext_pin_n[0] = 1'b0; tick();
        expect_offer(1'b1, 16'h0003, "R5 level low requests");
        ext_pin_n[0] = 1'b1; tick();
        expect_offer(1'b0, 16'h0, "R5 level follows pin high");
        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] p;
            p = m_pick();
            if ($urandom % 6 == 0) ext_pin_n[$urandom % 2] ^= 1'b1;
            if ($urandom % 9 == 0) tmr_ovf[$urandom % 2] = 1'b1;
            if ($urandom % 15 == 0) ser_tx_done = 1'b1;
            if ($urandom % 15 == 0) ser_rx_done = 1'b1;
            if ($urandom % 12 == 0) begin
                reg_we = 1'b1;
                reg_addr = 2'($urandom);
                reg_wdata = 8'($urandom);
                if (reg_addr == 2'd0 && ($urandom % 4 != 0)) reg_wdata[7] = 1'b1;
            end
            if (p[3] && $urandom % 2 == 0) irq_ack = 1'b1;
            else if ((m_hi || m_lo) && $urandom % 4 == 0) irq_reti = 1'b1;
            tick();
            if (n % 16 == 0) rd(2'd3, {2'b00, m_fl}, "R6 R7 R10 flag readback");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule